// File: doc/BRIEF.md
# FIFO Threshold Service Request Generator

This block sits between a serial controller's byte engine and the host side of a chip. It holds one byte queue for outgoing data and one for incoming data. It turns their fill levels into ready flags, interrupt requests and DMA requests. The host, whether a CPU or a DMA channel, moves data in bursts. The size of each burst is set by a per-direction threshold field. A request stays up until exactly one burst worth of accepted host accesses has been counted. It does not fall as soon as a level comparison changes.

A down-counter holds the remaining transfer length and tracks the bytes still expected on the line side. When the length is not a whole number of bursts, a shortened drain burst serves the final bytes, and a drain flag marks it. The outgoing direction never drains while the controller acts as a bus slave, because the remote master decides where that transfer ends. The ready flags do not depend on the interrupt and DMA enables, so software can poll them when both enables are off.

Top module: `svcreq_gen`

## Requirements
- R1: Each queue returns bytes in the order they were accepted. Its read port always shows the oldest stored byte. `tx_level` and `rx_level` report the number of bytes stored, from 0 to DEPTH.
- R2: A push into a full queue is dropped and sets the sticky overflow flag for that queue. A pop from an empty queue is dropped and sets the sticky underflow flag. A push and a pop on a full queue in the same cycle still drops the push. The flags stay set until reset.
- R3: The burst size of a direction is its threshold field plus one. When the receive side has no burst open and `rx_level` is greater than `rx_thr`, `rx_ready` rises at the next clock edge.
- R4: Once `rx_ready` is up, it falls on the clock edge of the accepted host pop that completes the burst. It stays up after fewer accepted pops.
- R5: When the transmit side has no burst open and the transmit queue is empty, `tx_ready` rises at the next clock edge. The drain rules of R10 can change this.
- R6: Once `tx_ready` is up, it falls on the clock edge of the accepted host push that completes the burst. It stays up after fewer accepted pushes.
- R7: After a burst completes, its ready flag is low for at least one cycle. It rises again only when its start condition is met again.
- R8: `len_load` loads the remaining count from `len_value`. Otherwise the count drops by one, stopping at zero, in each cycle that has an accepted line-side byte (a transmit pop or a receive push).
- R9: The receive side opens a drain burst when `drain_en` is 1, the remaining count is zero, and `rx_level` is between 1 and `rx_thr`. The drain burst size equals `rx_level`, and `rx_drain` is high while the burst is open.
- R10: While `drain_en` is 1 and `slave_tx` is 0, the empty transmit queue opens one of three kinds of burst. With a remaining count of at least the burst size, it opens a full burst. With a remaining count between 1 and the burst size minus one, it opens a drain burst of that many bytes, with `tx_drain` high. With a remaining count of zero, it opens no burst.
- R11: While `slave_tx` is 1, transmit bursts always have the full threshold size and `tx_drain` never rises.
- R12: Each interrupt output is its ready flag ANDed with the interrupt enable. Each DMA request is its ready flag ANDed with the DMA enable and with the inverse of the DMA clear input, all in the same cycle. Enables never change the ready flags.
- R13: While reset is held, both levels are zero and all flags and requests are low. The internal reset is released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Host writes a byte into the transmit queue |
| tx_wdata | input | DW | Byte written by the host |
| line_tx_pop | input | 1 | Line side takes the oldest transmit byte |
| line_tx_data | output | DW | Oldest transmit byte |
| tx_level | output | CW | Transmit queue fill level |
| line_rx_push | input | 1 | Line side delivers a received byte |
| line_rx_data | input | DW | Received byte |
| rx_pop | input | 1 | Host reads the oldest receive byte |
| rx_rdata | output | DW | Oldest receive byte |
| rx_level | output | CW | Receive queue fill level |
| tx_thr | input | AW | Transmit burst size minus one |
| rx_thr | input | AW | Receive burst size minus one |
| drain_en | input | 1 | Enables drain bursts |
| slave_tx | input | 1 | Controller transmits as a bus slave |
| len_load | input | 1 | Loads the remaining transfer count |
| len_value | input | LENW | Transfer length to load |
| irq_en_tx | input | 1 | Transmit interrupt enable |
| irq_en_rx | input | 1 | Receive interrupt enable |
| dma_en_tx | input | 1 | Transmit DMA enable |
| dma_en_rx | input | 1 | Receive DMA enable |
| dma_clr_tx | input | 1 | Forces the transmit DMA request low |
| dma_clr_rx | input | 1 | Forces the receive DMA request low |
| tx_ready | output | 1 | Transmit burst open |
| rx_ready | output | 1 | Receive burst open |
| tx_drain | output | 1 | Open transmit burst is a drain burst |
| rx_drain | output | 1 | Open receive burst is a drain burst |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| dma_req_tx | output | 1 | Transmit DMA request |
| dma_req_rx | output | 1 | Receive DMA request |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |

## Verification
The bench first targets an incomplete burst. A design that compares levels would drop `tx_ready` or `rx_ready` after one or two accesses, while the correct design must hold it until the last access of the burst. Next comes the short final burst: the drain size must come from the remaining count or the receive level. A wrong choice would leave the request stuck high or release it early, and a missed zero check would raise a transmit request with nothing left to send. Slave transmit mode must suppress draining, and a design that ignores it would raise `tx_drain`. Random traffic fills and empties both queues to probe dropped pushes and pops: a design that counted a dropped access toward a burst would release its request one access early.

// File: rtl/svcreq_pkg.sv
package svcreq_pkg;

  typedef enum logic {
    BK_FULL  = 1'b0,
    BK_DRAIN = 1'b1
  } burst_kind_e;

  typedef struct packed {
    logic        active;
    burst_kind_e kind;
  } burst_stat_t;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int NDIR   = 2;

endpackage

// File: rtl/svc_byte_fifo.sv
module svc_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] level,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf,
  output logic          udf
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_nx, rptr_q, rptr_nx;
  logic [CW-1:0] level_nx;
  logic          ovf_nx, udf_nx;

  always_comb begin
    push_ok  = push && (level != CW'(DEPTH));
    pop_ok   = pop && (level != '0);
    wptr_nx  = wptr_q;
    rptr_nx  = rptr_q;
    if (push_ok) wptr_nx = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (pop_ok)  rptr_nx = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    level_nx = level + CW'(push_ok) - CW'(pop_ok);
    ovf_nx   = ovf | (push & ~push_ok);
    udf_nx   = udf | (pop & ~pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      wptr_q <= wptr_nx;
      rptr_q <= rptr_nx;
      level  <= level_nx;
      ovf    <= ovf_nx;
      udf    <= udf_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];

endmodule

// File: rtl/svc_burst_track.sv
module svc_burst_track
  import svcreq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_full,
  input  logic          start_drain,
  input  logic [CW-1:0] full_size,
  input  logic [CW-1:0] drain_size,
  input  logic          tick,
  output burst_stat_t   stat
);

  logic          act_q, act_nx;
  burst_kind_e   kind_q, kind_nx;
  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    act_nx  = act_q;
    kind_nx = kind_q;
    cnt_nx  = cnt_q;
    if (!act_q) begin
      if (start_full) begin
        act_nx  = 1'b1;
        kind_nx = BK_FULL;
        cnt_nx  = full_size;
      end else if (start_drain) begin
        act_nx  = 1'b1;
        kind_nx = BK_DRAIN;
        cnt_nx  = drain_size;
      end
    end else if (tick) begin
      cnt_nx = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) act_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      kind_q <= BK_FULL;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_nx;
      kind_q <= kind_nx;
      cnt_q  <= cnt_nx;
    end
  end

  assign stat.active = act_q;
  assign stat.kind   = kind_q;

endmodule

// File: rtl/svcreq_gen.sv
module svcreq_gen
  import svcreq_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DEPTH      = 8,
  parameter int LENW       = 16,
  parameter int RST_STAGES = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_push,
  input  logic [DW-1:0]   tx_wdata,
  input  logic            line_tx_pop,
  output logic [DW-1:0]   line_tx_data,
  output logic [CW-1:0]   tx_level,
  input  logic            line_rx_push,
  input  logic [DW-1:0]   line_rx_data,
  input  logic            rx_pop,
  output logic [DW-1:0]   rx_rdata,
  output logic [CW-1:0]   rx_level,
  input  logic [AW-1:0]   tx_thr,
  input  logic [AW-1:0]   rx_thr,
  input  logic            drain_en,
  input  logic            slave_tx,
  input  logic            len_load,
  input  logic [LENW-1:0] len_value,
  input  logic            irq_en_tx,
  input  logic            irq_en_rx,
  input  logic            dma_en_tx,
  input  logic            dma_en_rx,
  input  logic            dma_clr_tx,
  input  logic            dma_clr_rx,
  output logic            tx_ready,
  output logic            rx_ready,
  output logic            tx_drain,
  output logic            rx_drain,
  output logic            irq_tx,
  output logic            irq_rx,
  output logic            dma_req_tx,
  output logic            dma_req_rx,
  output logic            tx_ovf,
  output logic            tx_udf,
  output logic            rx_ovf,
  output logic            rx_udf
);

  // Reset: asserted asynchronously, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rsync_q;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rsync_q[RST_STAGES-1];

  // Byte queues
  logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

  svc_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_core_n),
    .push(tx_push), .wdata(tx_wdata),
    .pop(line_tx_pop), .rdata(line_tx_data),
    .level(tx_level), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
    .ovf(tx_ovf), .udf(tx_udf)
  );

  svc_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_core_n),
    .push(line_rx_push), .wdata(line_rx_data),
    .pop(rx_pop), .rdata(rx_rdata),
    .level(rx_level), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
    .ovf(rx_ovf), .udf(rx_udf)
  );

  // Remaining transfer count
  logic [LENW-1:0] rem_q, rem_nx;

  always_comb begin
    rem_nx = rem_q;
    if (len_load)                                       rem_nx = len_value;
    else if ((tx_pop_ok || rx_push_ok) && rem_q != '0)  rem_nx = rem_q - LENW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else if (!rst_core_n) rem_q <= '0;
    else rem_q <= rem_nx;
  end

  // Burst start conditions per direction
  logic [CW-1:0] tx_burst, rx_burst;
  logic          tx_drain_on, rem_short, tx_empty;
  logic [NDIR-1:0] st_full, st_drain, tick;
  logic [CW-1:0] full_sz [NDIR];
  logic [CW-1:0] drain_sz [NDIR];
  burst_stat_t   stat [NDIR];

  always_comb begin
    tx_burst    = CW'(tx_thr) + CW'(1);
    rx_burst    = CW'(rx_thr) + CW'(1);
    tx_drain_on = drain_en & ~slave_tx;
    tx_empty    = (tx_level == '0);
    rem_short   = (rem_q < LENW'(tx_burst));

    st_full[DIR_TX]  = tx_empty && (!tx_drain_on || !rem_short);
    st_drain[DIR_TX] = tx_empty && tx_drain_on && rem_short && (rem_q != '0);
    full_sz[DIR_TX]  = tx_burst;
    drain_sz[DIR_TX] = rem_q[CW-1:0];
    tick[DIR_TX]     = tx_push_ok;

    st_full[DIR_RX]  = (rx_level > CW'(rx_thr));
    st_drain[DIR_RX] = drain_en && (rem_q == '0) && (rx_level != '0) && !st_full[DIR_RX];
    full_sz[DIR_RX]  = rx_burst;
    drain_sz[DIR_RX] = rx_level;
    tick[DIR_RX]     = rx_pop_ok;
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    svc_burst_track #(.CW(CW)) u_trk (
      .clk(clk), .rst_n(rst_core_n),
      .start_full(st_full[d]), .start_drain(st_drain[d]),
      .full_size(full_sz[d]), .drain_size(drain_sz[d]),
      .tick(tick[d]), .stat(stat[d])
    );
  end

  // Request outputs
  assign tx_ready   = stat[DIR_TX].active;
  assign rx_ready   = stat[DIR_RX].active;
  assign tx_drain   = stat[DIR_TX].active && (stat[DIR_TX].kind == BK_DRAIN);
  assign rx_drain   = stat[DIR_RX].active && (stat[DIR_RX].kind == BK_DRAIN);
  assign irq_tx     = tx_ready & irq_en_tx;
  assign irq_rx     = rx_ready & irq_en_rx;
  assign dma_req_tx = tx_ready & dma_en_tx & ~dma_clr_tx;
  assign dma_req_rx = rx_ready & dma_en_rx & ~dma_clr_rx;

endmodule

// File: rtl/svcreq_gen_chk.sv
module svcreq_gen_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_push,
  input logic          rx_pop,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic [AW-1:0] rx_thr,
  input logic          drain_en,
  input logic          slave_tx,
  input logic          dma_clr_tx,
  input logic          dma_clr_rx,
  input logic          tx_ready,
  input logic          rx_ready,
  input logic          tx_drain,
  input logic          rx_drain,
  input logic          irq_tx,
  input logic          irq_rx,
  input logic          dma_req_tx,
  input logic          dma_req_rx,
  input logic          tx_ovf,
  input logic          rx_udf
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH))); // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf); // R2
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_udf |=> rx_udf); // R2
  AST_RX_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_ready) && !rx_drain) |-> ($past(rx_level) > CW'($past(rx_thr)))); // R3
  AST_RX_FALL_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> ($past(rx_pop) && $past(rx_level) != '0)); // R4
  AST_TX_RISE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> ($past(tx_level) == '0)); // R5
  AST_TX_FALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> ($past(tx_push) && $past(tx_level) != CW'(DEPTH))); // R6
  AST_RX_DRAIN_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_drain) |-> $past(drain_en)); // R9
  AST_TX_DRAIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_drain) |-> ($past(drain_en) && !$past(slave_tx))); // R11
  AST_DMA_CLR_TX: assert property (@(posedge clk) disable iff (!rst_n)
    dma_clr_tx |-> !dma_req_tx); // R12
  AST_DMA_CLR_RX: assert property (@(posedge clk) disable iff (!rst_n)
    dma_clr_rx |-> !dma_req_rx); // R12
  AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx |-> tx_ready) and (irq_rx |-> rx_ready)); // R12

endmodule

bind svcreq_gen svcreq_gen_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_core_n),
  .tx_push(tx_push), .rx_pop(rx_pop),
  .tx_level(tx_level), .rx_level(rx_level), .rx_thr(rx_thr),
  .drain_en(drain_en), .slave_tx(slave_tx),
  .dma_clr_tx(dma_clr_tx), .dma_clr_rx(dma_clr_rx),
  .tx_ready(tx_ready), .rx_ready(rx_ready),
  .tx_drain(tx_drain), .rx_drain(rx_drain),
  .irq_tx(irq_tx), .irq_rx(irq_rx),
  .dma_req_tx(dma_req_tx), .dma_req_rx(dma_req_rx),
  .tx_ovf(tx_ovf), .rx_udf(rx_udf)
);

// File: tb/svcreq_gen_tb.sv
module svcreq_gen_tb;

  localparam int DW = 8, DEPTH = 8, LENW = 16, AW = 3, CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_push = 0, line_tx_pop = 0, line_rx_push = 0, rx_pop = 0;
  logic [DW-1:0] tx_wdata = '0, line_rx_data = '0;
  logic [DW-1:0] line_tx_data, rx_rdata;
  logic [CW-1:0] tx_level, rx_level;
  logic [AW-1:0] tx_thr = 3'd2, rx_thr = 3'd3;
  logic drain_en = 0, slave_tx = 0, len_load = 0;
  logic [LENW-1:0] len_value = '0;
  logic irq_en_tx = 0, irq_en_rx = 0, dma_en_tx = 0, dma_en_rx = 0;
  logic dma_clr_tx = 0, dma_clr_rx = 0;
  logic tx_ready, rx_ready, tx_drain, rx_drain, irq_tx, irq_rx;
  logic dma_req_tx, dma_req_rx, tx_ovf, tx_udf, rx_ovf, rx_udf;

  always #2 clk = ~clk;

  svcreq_gen #(.DW(DW), .DEPTH(DEPTH), .LENW(LENW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_push(tx_push), .tx_wdata(tx_wdata),
    .line_tx_pop(line_tx_pop), .line_tx_data(line_tx_data), .tx_level(tx_level),
    .line_rx_push(line_rx_push), .line_rx_data(line_rx_data),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .drain_en(drain_en), .slave_tx(slave_tx),
    .len_load(len_load), .len_value(len_value),
    .irq_en_tx(irq_en_tx), .irq_en_rx(irq_en_rx),
    .dma_en_tx(dma_en_tx), .dma_en_rx(dma_en_rx),
    .dma_clr_tx(dma_clr_tx), .dma_clr_rx(dma_clr_rx),
    .tx_ready(tx_ready), .rx_ready(rx_ready),
    .tx_drain(tx_drain), .rx_drain(rx_drain),
    .irq_tx(irq_tx), .irq_rx(irq_rx),
    .dma_req_tx(dma_req_tx), .dma_req_rx(dma_req_rx),
    .tx_ovf(tx_ovf), .tx_udf(tx_udf), .rx_ovf(rx_ovf), .rx_udf(rx_udf)
  );

  int n_chk = 0, n_bad = 0;

  // Reference model state
  int mtx[$];
  int mrx[$];
  bit m_tovf, m_tudf, m_rovf, m_rudf;
  int mrem;
  bit t_act, t_drn, r_act, r_drn;
  int t_cnt, r_cnt;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mtx.delete(); mrx.delete();
    m_tovf = 0; m_tudf = 0; m_rovf = 0; m_rudf = 0;
    mrem = 0; t_act = 0; t_drn = 0; r_act = 0; r_drn = 0; t_cnt = 0; r_cnt = 0;
  endtask

  task automatic model_edge();
    int tl, rl, tb, rb;
    bit tpush_ok, tpop_ok, rpush_ok, rpop_ok, tdon;
    tl = mtx.size(); rl = mrx.size();
    tpush_ok = tx_push && tl < DEPTH;
    tpop_ok  = line_tx_pop && tl > 0;
    rpush_ok = line_rx_push && rl < DEPTH;
    rpop_ok  = rx_pop && rl > 0;
    tb = int'(tx_thr) + 1; rb = int'(rx_thr) + 1;
    tdon = drain_en && !slave_tx;
    if (!t_act) begin
      if (tl == 0) begin
        if (!tdon || mrem >= tb) begin t_act = 1; t_drn = 0; t_cnt = tb; end
        else if (mrem > 0)      begin t_act = 1; t_drn = 1; t_cnt = mrem; end
      end
    end else if (tpush_ok) begin
      t_cnt--; if (t_cnt == 0) t_act = 0;
    end
    if (!r_act) begin
      if (rl >= rb) begin r_act = 1; r_drn = 0; r_cnt = rb; end
      else if (drain_en && mrem == 0 && rl > 0) begin r_act = 1; r_drn = 1; r_cnt = rl; end
    end else if (rpop_ok) begin
      r_cnt--; if (r_cnt == 0) r_act = 0;
    end
    if (tpop_ok) void'(mtx.pop_front());
    if (tpush_ok) mtx.push_back(int'(tx_wdata));
    if (rpop_ok) void'(mrx.pop_front());
    if (rpush_ok) mrx.push_back(int'(line_rx_data));
    if (tx_push && !tpush_ok) m_tovf = 1;
    if (line_tx_pop && !tpop_ok) m_tudf = 1;
    if (line_rx_push && !rpush_ok) m_rovf = 1;
    if (rx_pop && !rpop_ok) m_rudf = 1;
    if (len_load) mrem = int'(len_value);
    else if ((tpop_ok || rpush_ok) && mrem > 0) mrem--;
  endtask

  task automatic compare();
    chk("R1", "tx_level", int'(tx_level), mtx.size());
    chk("R1", "rx_level", int'(rx_level), mrx.size());
    if (mtx.size() > 0) chk("R1", "line_tx_data", int'(line_tx_data), mtx[0]);
    if (mrx.size() > 0) chk("R1", "rx_rdata", int'(rx_rdata), mrx[0]);
    chk("R2", "tx_ovf", int'(tx_ovf), int'(m_tovf));
    chk("R2", "tx_udf", int'(tx_udf), int'(m_tudf));
    chk("R2", "rx_ovf", int'(rx_ovf), int'(m_rovf));
    chk("R2", "rx_udf", int'(rx_udf), int'(m_rudf));
    chk("R6", "tx_ready", int'(tx_ready), int'(t_act));
    chk("R4", "rx_ready", int'(rx_ready), int'(r_act));
    chk("R10", "tx_drain", int'(tx_drain), int'(t_act && t_drn));
    chk("R9", "rx_drain", int'(rx_drain), int'(r_act && r_drn));
    chk("R12", "irq_tx", int'(irq_tx), int'(irq_en_tx && t_act));
    chk("R12", "irq_rx", int'(irq_rx), int'(irq_en_rx && r_act));
    chk("R12", "dma_req_tx", int'(dma_req_tx), int'(dma_en_tx && !dma_clr_tx && t_act));
    chk("R12", "dma_req_rx", int'(dma_req_rx), int'(dma_en_rx && !dma_clr_rx && r_act));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", "tx_level", int'(tx_level), 0);
    chk("R13", "rx_level", int'(rx_level), 0);
    chk("R13", "ready", int'({tx_ready, rx_ready, tx_drain, rx_drain}), 0);
    chk("R13", "flags", int'({tx_ovf, tx_udf, rx_ovf, rx_udf}), 0);
    chk("R13", "req", int'({irq_tx, irq_rx, dma_req_tx, dma_req_rx}), 0);
    rst_n = 1'b1;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R13", "tx_ready held by sync", int'(tx_ready), 0);

    // R5: empty transmit queue opens a burst (burst size 3)
    step();
    chk("R5", "tx_ready after empty", int'(tx_ready), 1);
    tx_push = 1;
    tx_wdata = 8'h11; step();
    tx_wdata = 8'h22; step();
    chk("R6", "tx_ready after 2 of 3", int'(tx_ready), 1);
    tx_wdata = 8'h33; step();
    chk("R6", "tx_ready after 3 of 3", int'(tx_ready), 0);
    tx_push = 0; step();
    chk("R7", "tx_ready while queue holds data", int'(tx_ready), 0);
    line_tx_pop = 1;
    repeat (3) step();
    line_tx_pop = 0; step();
    chk("R7", "tx_ready re-armed on empty", int'(tx_ready), 1);

    // R8 / R10: transfer length 5 with burst 3 -> full burst then drain of 2
    drain_en = 1; len_load = 1; len_value = 16'd5; step();
    len_load = 0;
    tx_push = 1; repeat (3) step();
    tx_push = 0; line_tx_pop = 1; repeat (3) step();
    line_tx_pop = 0; step();
    chk("R8", "tx_ready for remaining 2", int'(tx_ready), 1);
    chk("R10", "tx_drain for remaining 2", int'(tx_drain), 1);
    tx_push = 1; repeat (2) step();
    tx_push = 0;
    chk("R10", "tx_ready after drain burst", int'(tx_ready), 0);
    line_tx_pop = 1; repeat (2) step();
    line_tx_pop = 0; repeat (2) step();
    chk("R10", "tx_ready with zero remaining", int'(tx_ready), 0);
    chk("R8", "no request once count hit zero", int'(tx_drain), 0);

    // R11: slave transmit ignores the count
    slave_tx = 1; step();
    chk("R11", "tx_ready in slave mode", int'(tx_ready), 1);
    chk("R11", "tx_drain in slave mode", int'(tx_drain), 0);

    // R3 / R4 / R9: receive burst 4, length 6
    len_load = 1; len_value = 16'd6; step();
    len_load = 0; line_rx_push = 1;
    for (int i = 0; i < 4; i++) begin line_rx_data = 8'(8'hA0 + i); step(); end
    line_rx_push = 0;
    chk("R3", "rx_ready at level 4 same edge", int'(rx_ready), 0);
    step();
    chk("R3", "rx_ready after level exceeds threshold", int'(rx_ready), 1);
    rx_pop = 1; repeat (3) step();
    chk("R4", "rx_ready after 3 of 4 pops", int'(rx_ready), 1);
    step();
    chk("R4", "rx_ready after 4 of 4 pops", int'(rx_ready), 0);
    rx_pop = 0; line_rx_push = 1; repeat (2) step();
    line_rx_push = 0; step();
    chk("R9", "rx_ready for partial burst", int'(rx_ready), 1);
    chk("R9", "rx_drain for partial burst", int'(rx_drain), 1);
    rx_pop = 1; repeat (2) step();
    chk("R9", "rx_ready after drain pops", int'(rx_ready), 0);
    step();
    chk("R2", "rx_udf after pop on empty", int'(rx_udf), 1);
    rx_pop = 0;

    // R12: enables and the clear input
    irq_en_tx = 1; dma_en_tx = 1; step();
    chk("R12", "irq_tx", int'(irq_tx), 1);
    chk("R12", "dma_req_tx", int'(dma_req_tx), 1);
    dma_clr_tx = 1; #1;
    chk("R12", "dma_req_tx with clear", int'(dma_req_tx), 0);
    chk("R12", "tx_ready with clear", int'(tx_ready), 1);
    step();
    dma_clr_tx = 0;

    // Random traffic in phases of different fill bias
    for (int ph = 0; ph < 8; ph++) begin
      int pin, pout;
      pin  = (ph % 2 == 0) ? 60 : 25;
      pout = (ph % 2 == 0) ? 25 : 60;
      for (int c = 0; c < 500; c++) begin
        tx_push      = ($urandom % 100) < pin;
        tx_wdata     = 8'($urandom);
        line_tx_pop  = ($urandom % 100) < pout;
        line_rx_push = ($urandom % 100) < pin;
        line_rx_data = 8'($urandom);
        rx_pop       = ($urandom % 100) < pout;
        len_load     = ($urandom % 100) < 3;
        len_value    = 16'($urandom % 24);
        if (($urandom % 100) < 2) tx_thr = 3'($urandom);
        if (($urandom % 100) < 2) rx_thr = 3'($urandom);
        if (($urandom % 100) < 2) drain_en = ~drain_en;
        if (($urandom % 100) < 2) slave_tx = ~slave_tx;
        if (($urandom % 100) < 5) irq_en_tx = ~irq_en_tx;
        if (($urandom % 100) < 5) irq_en_rx = ~irq_en_rx;
        if (($urandom % 100) < 5) dma_en_tx = ~dma_en_tx;
        if (($urandom % 100) < 5) dma_en_rx = ~dma_en_rx;
        dma_clr_tx = ($urandom % 100) < 10;
        dma_clr_rx = ($urandom % 100) < 10;
        step();
      end
    end
    report();
  end

endmodule